// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a segment:offset pair into a linear address. It has one segment register. The visible part is a 16-bit selector. Behind it sits a hidden copy of the decoded descriptor for that selector. In real mode the selector is used as a paragraph number: it is shifted left by four bits and added to a 16-bit offset, which gives a 20-bit address. In protected mode the selector picks a 64-bit descriptor from one of two small internal tables, a global one and a local one. The offset is checked against the limit and the access rights taken from that descriptor, and then added to the 32-bit base.

Software first fills the tables through a write port. It then loads a selector. The load reads the table in one cycle and writes the hidden cache in the next. Translation requests are taken only while `ready` is high. Each accepted request gives, one cycle later, either a one-cycle valid address or a one-cycle fault code.

Top module: `segXlate`

## Requirements
- R1: With `protMode` low, an accepted request gives `linValid` high one cycle later. `linAddr` is then ((selector × 16) + `reqOffset[15:0]`) modulo 2^20, bits 31:20 are zero, `reqOffset[31:16]` has no effect, and no fault is raised.
- R2: Selector bits 15:3 form the table index. Bit 2 picks the table: 0 is global, 1 is local. Bits 1:0 have no effect on protected-mode results.
- R3: A load is accepted when `selLoad` and `ready` are both high. `ready` is then low for exactly the two following cycles. A `selLoad` or `reqValid` seen while `ready` is low is ignored and gives no output.
- R4: When `tblWrEn` is high, `tblWrData` is stored at entry `tblWrIdx` of the local table (`tblWrLocal`=1) or the global table (`tblWrLocal`=0). The descriptor fields are: limit = {bits 51:48, bits 15:0}, base = {bits 63:56, bits 39:16}, access byte = bits 47:40, granularity = bit 55.
- R5: In protected mode a request that passes all checks gives `linAddr` = (base + `reqOffset`) modulo 2^32.
- R6: The effective limit is the 20-bit limit when granularity is 0. When granularity is 1 it is {limit, 12'hFFF}. An offset above the effective limit gives `faultCode`=2 and no `linValid`.
- R7: A write request (`reqWrite`=1) faults with `faultCode`=3 when access bit 3 is set (code segment) or access bit 1 is clear (read-only data). Reads are never refused for rights.
- R8: In protected mode, `faultCode`=1 is raised on any access when the selector is null (index 0 with bit 2 clear) or its index is not below `TBL_DEPTH`. This also holds after reset, before any load.
- R9: When several faults apply, the order is selector fault, then limit fault, then rights fault.
- R10: When `selLoad` and `reqValid` are both high in a ready cycle, the request is translated with the descriptor and selector that were in place before the load.
- R11: During and after reset, `ready` is high and `linValid` and `faultCode` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| protMode | input | 1 | 1 = protected translation, 0 = real mode |
| tblWrEn | input | 1 | Descriptor table write strobe |
| tblWrLocal | input | 1 | Write targets the local table when 1 |
| tblWrIdx | input | IDX_W | Table entry written |
| tblWrData | input | 64 | Descriptor written |
| selLoad | input | 1 | Load `selValue` into the segment register |
| selValue | input | 16 | Selector to load |
| ready | output | 1 | High when a load or request can be accepted |
| reqValid | input | 1 | Translation request |
| reqWrite | input | 1 | Request is a write |
| reqOffset | input | 32 | Offset to translate |
| linValid | output | 1 | One-cycle pulse: `linAddr` is valid |
| linAddr | output | 32 | Translated linear address |
| faultCode | output | 2 | 0 none, 1 bad selector, 2 limit, 3 rights |

## Verification
The assertions run on every cycle. They check that an accepted load always drops `ready` for exactly two cycles, that an address and a fault never come out together, and that nothing comes out for a request that was not accepted. They also check that every real-mode request gives a valid address below 2^20, and that a read never gets a rights fault. The actual address values, limit boundaries at both granularities, base wraparound, fault priority, ignored selector bits and the meaning of a load and a request in the same cycle can only be shown by the bench scenarios, which compare against a model of the tables and the hidden descriptor.

// File: rtl/segXlatePkg.sv
package segXlatePkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_SEL    = 2'd1,
    FLT_LIMIT  = 2'd2,
    FLT_RIGHTS = 2'd3
  } faultE;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } ctrlStateE;

  typedef struct packed {
    logic captureSel;
    logic readTable;
    logic writeCache;
    logic acceptReq;
  } strobeT;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] effLimit;
    logic        isCode;
    logic        writable;
    logic        bad;
  } segCacheT;

  // Unpack an 8-byte descriptor into the form the translation path uses.
  function automatic segCacheT decodeDesc(input logic [63:0] d, input logic bad);
    segCacheT c;
    logic [19:0] lim;
    lim        = {d[51:48], d[15:0]};
    c.base     = {d[63:56], d[39:16]};
    c.effLimit = d[55] ? {lim, 12'hFFF} : {12'h000, lim};
    c.isCode   = d[43];
    c.writable = d[41];
    c.bad      = bad;
    return c;
  endfunction

endpackage

// File: rtl/segXlateCtrl.sv
module segXlateCtrl
  import segXlatePkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   selLoad,
  input  logic   reqValid,
  output logic   ready,
  output strobeT strobe
);

  ctrlStateE state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (selLoad) stateNext = ST_READ;
      ST_READ:  stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign ready             = (state == ST_IDLE);
  assign strobe.captureSel = ready && selLoad;
  assign strobe.acceptReq  = ready && reqValid;
  assign strobe.readTable  = (state == ST_READ);
  assign strobe.writeCache = (state == ST_WRITE);

endmodule

// File: rtl/segXlateDatapath.sv
module segXlateDatapath
  import segXlatePkg::*;
#(
  parameter int TBL_DEPTH = 16,
  parameter int IDX_W     = $clog2(TBL_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  logic             protMode,
  input  logic             tblWrEn,
  input  logic             tblWrLocal,
  input  logic [IDX_W-1:0] tblWrIdx,
  input  logic [63:0]      tblWrData,
  input  logic [15:0]      selValue,
  input  logic             reqWrite,
  input  logic [31:0]      reqOffset,
  output logic             linValid,
  output logic [31:0]      linAddr,
  output logic [1:0]       faultCode
);

  localparam int SEL_IDX_W = 13;

  logic [63:0] globalTbl [TBL_DEPTH];
  logic [63:0] localTbl  [TBL_DEPTH];

  logic [15:0]          selReg;
  logic [SEL_IDX_W-1:0] selIdx;
  logic                 selLocal;
  logic                 idxInRange;
  logic [63:0]          stageDesc;
  logic                 stageBad;
  segCacheT             cache;
  logic [19:0]          realSum;

  assign selIdx     = selReg[15:3];
  assign selLocal   = selReg[2];
  assign idxInRange = ({19'd0, selIdx} < TBL_DEPTH);
  assign realSum    = {selReg, 4'h0} + {4'h0, reqOffset[15:0]};

  // Descriptor tables: written by software, read once per selector load.
  always_ff @(posedge clk) begin
    if (tblWrEn) begin
      if (tblWrLocal) localTbl[tblWrIdx]  <= tblWrData;
      else            globalTbl[tblWrIdx] <= tblWrData;
    end
    if (strobe.readTable) begin
      stageDesc <= selLocal ? localTbl[selIdx[IDX_W-1:0]] : globalTbl[selIdx[IDX_W-1:0]];
      stageBad  <= (!selLocal && selIdx == '0) || !idxInRange;
    end
  end

  // Visible selector and hidden descriptor.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      cache  <= '{base: '0, effLimit: '0, isCode: 1'b0, writable: 1'b0, bad: 1'b1};
    end else begin
      if (strobe.captureSel) selReg <= selValue;
      if (strobe.writeCache) cache  <= decodeDesc(stageDesc, stageBad);
    end
  end

  // Translation and checks, one registered result per accepted request.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linValid  <= 1'b0;
      linAddr   <= '0;
      faultCode <= FLT_NONE;
    end else begin
      linValid  <= 1'b0;
      faultCode <= FLT_NONE;
      if (strobe.acceptReq) begin
        if (!protMode) begin
          linValid <= 1'b1;
          linAddr  <= {12'h000, realSum};
        end else if (cache.bad) begin
          faultCode <= FLT_SEL;
        end else if (reqOffset > cache.effLimit) begin
          faultCode <= FLT_LIMIT;
        end else if (reqWrite && (cache.isCode || !cache.writable)) begin
          faultCode <= FLT_RIGHTS;
        end else begin
          linValid <= 1'b1;
          linAddr  <= cache.base + reqOffset;
        end
      end
    end
  end

endmodule

// File: rtl/segXlate.sv
module segXlate
  import segXlatePkg::*;
#(
  parameter int TBL_DEPTH = 16,
  parameter int IDX_W     = $clog2(TBL_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             protMode,
  input  logic             tblWrEn,
  input  logic             tblWrLocal,
  input  logic [IDX_W-1:0] tblWrIdx,
  input  logic [63:0]      tblWrData,
  input  logic             selLoad,
  input  logic [15:0]      selValue,
  output logic             ready,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [31:0]      reqOffset,
  output logic             linValid,
  output logic [31:0]      linAddr,
  output logic [1:0]       faultCode
);

  strobeT strobe;

  segXlateCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .selLoad  (selLoad),
    .reqValid (reqValid),
    .ready    (ready),
    .strobe   (strobe)
  );

  segXlateDatapath #(.TBL_DEPTH(TBL_DEPTH), .IDX_W(IDX_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .protMode   (protMode),
    .tblWrEn    (tblWrEn),
    .tblWrLocal (tblWrLocal),
    .tblWrIdx   (tblWrIdx),
    .tblWrData  (tblWrData),
    .selValue   (selValue),
    .reqWrite   (reqWrite),
    .reqOffset  (reqOffset),
    .linValid   (linValid),
    .linAddr    (linAddr),
    .faultCode  (faultCode)
  );

endmodule

// File: rtl/segXlateChk.sv
module segXlateChk (
  input logic        clk,
  input logic        rstN,
  input logic        ready,
  input logic        selLoad,
  input logic        reqValid,
  input logic        reqWrite,
  input logic        protMode,
  input logic        linValid,
  input logic [31:0] linAddr,
  input logic [1:0]  faultCode
);

  // R3: an accepted load holds ready low for exactly two cycles
  a_r3_load_stall: assert property (@(posedge clk) disable iff (!rstN)
    (ready && selLoad) |=> (!ready ##1 !ready ##1 ready));

  // R3: a cycle without an accepted request yields no result
  a_r3_no_result_unaccepted: assert property (@(posedge clk) disable iff (!rstN)
    (!ready || !reqValid) |=> (!linValid && faultCode == 2'd0));

  // R6: a fault never comes out together with a valid address
  a_r6_fault_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !(linValid && faultCode != 2'd0));

  // R1: real mode always gives a valid address inside 20 bits
  a_r1_real_mode: assert property (@(posedge clk) disable iff (!rstN)
    (ready && reqValid && !protMode) |=> (linValid && linAddr[31:20] == 12'h000));

  // R7: reads never get a rights fault
  a_r7_read_no_rights: assert property (@(posedge clk) disable iff (!rstN)
    (ready && reqValid && !reqWrite) |=> (faultCode != 2'd3));

endmodule

bind segXlate segXlateChk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .ready     (ready),
  .selLoad   (selLoad),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .protMode  (protMode),
  .linValid  (linValid),
  .linAddr   (linAddr),
  .faultCode (faultCode)
);

// File: tb/tb_segXlate.sv
module tb_segXlate;

  localparam int DEPTH = 16;
  localparam int IW    = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          protMode = 1'b0;
  logic          tblWrEn = 1'b0;
  logic          tblWrLocal = 1'b0;
  logic [IW-1:0] tblWrIdx = '0;
  logic [63:0]   tblWrData = '0;
  logic          selLoad = 1'b0;
  logic [15:0]   selValue = '0;
  logic          ready;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [31:0]   reqOffset = '0;
  logic          linValid;
  logic [31:0]   linAddr;
  logic [1:0]    faultCode;

  always #10 clk = ~clk;

  segXlate #(.TBL_DEPTH(DEPTH), .IDX_W(IW)) dut (.*);

  int    checks = 0;
  int    fails  = 0;
  int    cycleCnt = 0;
  bit    done = 0;
  string curReq = "R11";

  // Behavioural reference model
  logic [63:0] mGdt [DEPTH];
  logic [63:0] mLdt [DEPTH];
  int          mState = 0;
  logic [15:0] mSel = '0;
  logic [63:0] mDesc = '0, mStage = '0;
  bit          mBad = 1, mStageBad = 1;
  bit          eValid = 0;
  logic [31:0] eAddr = '0;
  logic [1:0]  eFault = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mSel = '0; mBad = 1; eValid = 0; eFault = 0;
    end else begin
      eValid = 0; eFault = 0;
      if (mState == 0 && reqValid) begin
        if (!protMode) begin
          eValid = 1;
          eAddr  = 32'((longint'(mSel) * 16 + longint'(reqOffset[15:0])) % 64'h100000);
        end else if (mBad) begin
          eFault = 1;
        end else begin
          longint lim, eff;
          lim = longint'({mDesc[51:48], mDesc[15:0]});
          eff = mDesc[55] ? lim * 4096 + 4095 : lim;
          if (longint'(reqOffset) > eff) eFault = 2;
          else if (reqWrite && (mDesc[43] || !mDesc[41])) eFault = 3;
          else begin
            eValid = 1;
            eAddr  = 32'(longint'({mDesc[63:56], mDesc[39:16]}) + longint'(reqOffset));
          end
        end
      end
      case (mState)
        0: if (selLoad) begin mSel = selValue; mState = 1; end
        1: begin
          int idx;
          idx = int'(mSel >> 3);
          mStageBad = (idx == 0 && !mSel[2]) || idx >= DEPTH;
          mStage = (idx < DEPTH) ? (mSel[2] ? mLdt[idx] : mGdt[idx]) : 64'd0;
          mState = 2;
        end
        default: begin mDesc = mStage; mBad = mStageBad; mState = 0; end
      endcase
      if (tblWrEn) begin
        if (tblWrLocal) mLdt[tblWrIdx] = tblWrData;
        else            mGdt[tblWrIdx] = tblWrData;
      end
    end
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (ready !== (mState == 0) || linValid !== eValid || faultCode !== eFault ||
          (eValid && linAddr !== eAddr)) begin
        fails++;
        $display("FAIL %s: ready=%0b valid=%0b addr=%h fault=%0d, expected ready=%0b valid=%0b addr=%h fault=%0d",
                 curReq, ready, linValid, linAddr, faultCode, (mState == 0), eValid, eAddr, eFault);
      end
    end
  end

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt >= 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual cycles=%0d expected < 100000", cycleCnt);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [63:0] mkDesc(logic [31:0] base, logic [19:0] lim,
                                         logic [7:0] acc, logic gran);
    logic [63:0] d;
    d = '0;
    d[15:0] = lim[15:0];  d[51:48] = lim[19:16];
    d[39:16] = base[23:0]; d[63:56] = base[31:24];
    d[47:40] = acc;        d[55] = gran;
    return d;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrTbl(logic loc, logic [IW-1:0] idx, logic [63:0] d);
    @(negedge clk);
    tblWrEn = 1; tblWrLocal = loc; tblWrIdx = idx; tblWrData = d;
    @(negedge clk);
    tblWrEn = 0;
  endtask

  task automatic loadSel(logic [15:0] v);
    @(negedge clk);
    selLoad = 1; selValue = v;
    @(negedge clk);
    selLoad = 0;
    idle(2);
  endtask

  task automatic req(logic wr, logic [31:0] off);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqOffset = off;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
  endtask

  initial begin
    // R11 reset state
    idle(3);
    @(negedge clk); rstN = 1;
    idle(2);

    // R1 real mode
    curReq = "R1";
    loadSel(16'hA1F0); req(0, 32'h0000_04C0);
    loadSel(16'h028F); req(1, 32'hDEAD_0030);
    loadSel(16'hFFFF); req(0, 32'h0000_FFFF);

    // R8 bad selector after reset path and null selector
    curReq = "R8";
    protMode = 1;
    req(0, 32'h0);
    loadSel(16'h0003); req(0, 32'h10);
    loadSel(16'h00A0); req(0, 32'h10);

    // R4 table fill
    curReq = "R4";
    wrTbl(0, 4'd1, mkDesc(32'h1234_5000, 20'h00FFF, 8'h92, 0));
    wrTbl(1, 4'd2, mkDesc(32'hFFFF_F000, 20'h00001, 8'h90, 1));
    wrTbl(0, 4'd3, mkDesc(32'h0004_0000, 20'hFFFFF, 8'h9A, 0));
    wrTbl(1, 4'd0, mkDesc(32'h0000_7000, 20'h00010, 8'h92, 0));

    // R2 index, table select, ignored low bits; R5 base add; R6 byte limit
    curReq = "R2";
    loadSel(16'h000B); req(0, 32'h0);
    curReq = "R5";
    req(1, 32'h10);
    curReq = "R6";
    req(0, 32'h0FFF); req(0, 32'h1000);
    curReq = "R2";
    loadSel(16'h0008); req(0, 32'h0FFF);
    loadSel(16'h0004); req(0, 32'h5);

    // R6 page granularity, R5 wrap, R7 read-only, R9 priority
    curReq = "R6";
    loadSel(16'h0014); req(0, 32'h1FFF); req(0, 32'h2000);
    curReq = "R7";
    req(1, 32'h10);
    curReq = "R9";
    req(1, 32'h3000);
    curReq = "R7";
    loadSel(16'h0018); req(1, 32'h20); req(0, 32'h20);
    curReq = "R9";
    loadSel(16'h0000); req(1, 32'hFFFF_FFFF);

    // R3 requests and loads during a load are ignored
    curReq = "R3";
    @(negedge clk); selLoad = 1; selValue = 16'h000B;
    @(negedge clk); selLoad = 1; selValue = 16'h0014; reqValid = 1; reqOffset = 32'h4;
    @(negedge clk); selLoad = 0;
    @(negedge clk); reqValid = 0;
    req(1, 32'h20);

    // R10 load and request in the same cycle use the old descriptor
    curReq = "R10";
    @(negedge clk); selLoad = 1; selValue = 16'h0014; reqValid = 1; reqWrite = 1; reqOffset = 32'h30;
    @(negedge clk); selLoad = 0; reqValid = 0; reqWrite = 0;
    idle(2);
    req(1, 32'h30);
    protMode = 0;
    @(negedge clk); selLoad = 1; selValue = 16'h1000; reqValid = 1; reqOffset = 32'h1;
    @(negedge clk); selLoad = 0; reqValid = 0;
    idle(2);
    req(0, 32'h1);

    // R11 reset again in the middle of traffic
    curReq = "R11";
    @(negedge clk); rstN = 0;
    idle(2);
    @(negedge clk); rstN = 1;
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule